// File: doc/BRIEF.md
# Prioritized Processor Interrupt Selector

This block keeps a pending flag for each of seven processor interrupt sources and, when the core asks, names the one source that may be taken now. Sources are raised by a post strobe that carries a 4-bit type index. A request strobe makes the block evaluate the pending flags against the current processor context. The context is the hypervisor-privilege bit, the interrupt-enable bit, a trap-level-zero enable, the current trap level, a 16-bit soft-interrupt register and a 4-bit processor interrupt level. One cycle later the block answers with a response pulse, an encoded trap kind and, for soft interrupts, the level number. The source that was taken loses its pending flag.

The priority order is not fixed. It depends on the privilege mode and on the enable bits. A pending platform interrupt vector also slots in between soft-interrupt levels 5 and 6. A pending counter counts posts and takes, and the interrupt-present output follows that counter rather than the flags.

A small controller paces the responses. It has two states. In `ST_IDLE` no response is driven. In `ST_RESP` the response pulse is high for the cycle after a request. There are four transitions. `ST_IDLE` goes to `ST_RESP` on a request. `ST_RESP` stays in `ST_RESP` when a new request arrives back-to-back. `ST_RESP` returns to `ST_IDLE` when there is no request. `ST_IDLE` stays in `ST_IDLE` when there is no request. The choice itself is combinational from the registered flags. At the request edge, the result registers and the flag and counter updates capture that choice.

Top module: `tsel_top`

## Requirements
- R1: A legal post (type 0 = trap-level-zero, 1 = tick match, 2 = interrupt vector, 3 = CPU mondo, 4 = device mondo, 5 = resumable error, 6 = soft interrupt) sets that source's flag and adds one to the pending counter. `irq_pending` is high in the cycle after the post edge and stays high while the counter is nonzero, even when no flag remains.
- R2: A post with a type of 7 or above pulses `post_err` for exactly one cycle after the edge, and changes no flag and no count.
- R3: The pending counter holds at its maximum (15 by default) instead of wrapping, and holds at zero instead of going below it.
- R4: Each request edge produces exactly one `resp_vld` pulse in the next cycle. `resp_kind` uses the encoding 0 = none, 1 = trap-level-zero, 2 = tick match, 3 = interrupt vector, 4 = CPU mondo, 5 = device mondo, 6 = soft level, 7 = resumable error. Kind 0 is reported when nothing is eligible.
- R5: With hypervisor privilege set, nothing is taken while interrupt enable is low. With enable high, tick match is taken first and interrupt vector second, and no other source is taken.
- R6: Without hypervisor privilege, trap-level-zero has the highest priority. It is taken only while its enable is high and the trap level is 0.
- R7: Without hypervisor privilege, tick match comes next and is taken whatever the state of interrupt enable. After it, and only with enable high, the order is CPU mondo, device mondo, soft interrupt, resumable error.
- R8: The soft level is the index of the highest set bit among bits 15..1 of `softint`. Bit 0 is ignored, and no set bit gives level 0. A soft interrupt is taken only when its level is strictly above `pil`, and `resp_level` then reports that level. `resp_level` is 0 for every other kind.
- R9: When the soft source is pending with a level below 6 and the interrupt vector is pending, the interrupt vector is taken in the soft interrupt's place.
- R10: Taking a source clears its flag and subtracts one from the counter. The soft flag is cleared only when no bit among 15..1 of `softint` remains set once the taken level's bit is removed.
- R11: If a post and a take hit the same source at the same edge, that source stays pending afterwards and the counter is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_vld | input | 1 | Post strobe |
| post_type | input | 4 | Source index for the post |
| hpriv | input | 1 | Hypervisor-privilege mode |
| ie | input | 1 | Interrupt enable |
| tlz_en | input | 1 | Trap-level-zero enable |
| tl | input | 3 | Current trap level |
| softint | input | 16 | Soft-interrupt register |
| pil | input | 4 | Processor interrupt level |
| req | input | 1 | Take request strobe |
| irq_pending | output | 1 | Pending counter is nonzero |
| post_err | output | 1 | Illegal post seen (one-cycle pulse) |
| resp_vld | output | 1 | Response pulse |
| resp_kind | output | 3 | Encoded trap kind |
| resp_level | output | 4 | Soft level for a soft take, else 0 |

## Verification
A post and a take can land on the same edge. They may hit the same source, or different sources, and both move the pending counter. The bench provokes the same-source case by posting the CPU mondo while it is already pending, with a request asserted in the same cycle. It then judges the outcome at the ports. The response must name the CPU mondo. A second request must name it again. Only after that second take may `irq_pending` fall. The soft source adds a further overlap, because a take can decrement the counter without clearing the flag. Repeated soft takes after the counter has reached zero must leave `irq_pending` low.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

    localparam int NSRC      = 7;
    localparam int SRC_W     = $clog2(NSRC);
    localparam int VEC_SPLIT = 6;

    typedef enum logic [SRC_W-1:0] {
        SRC_TLZ  = 3'd0,
        SRC_TICK = 3'd1,
        SRC_VEC  = 3'd2,
        SRC_CPU  = 3'd3,
        SRC_DEV  = 3'd4,
        SRC_RERR = 3'd5,
        SRC_SOFT = 3'd6
    } src_e;

    typedef enum logic [2:0] {
        KIND_NONE = 3'd0,
        KIND_TLZ  = 3'd1,
        KIND_TICK = 3'd2,
        KIND_VEC  = 3'd3,
        KIND_CPU  = 3'd4,
        KIND_DEV  = 3'd5,
        KIND_SOFT = 3'd6,
        KIND_RERR = 3'd7
    } kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rstate_e;

endpackage

// File: rtl/tsel_softlvl.sv
module tsel_softlvl #(
    parameter int SW = 16,
    parameter int LW = $clog2(SW)
) (
    input  logic [SW-1:0] vec,
    output logic [LW-1:0] level
);

    // Highest set bit wins; bit 0 never contributes a level.
    always_comb begin
        level = '0;
        for (int i = 0; i < SW; i++) begin
            if (vec[i] && (i != 0)) begin
                level = LW'(i);
            end
        end
    end

endmodule

// File: rtl/tsel_pick.sv
module tsel_pick
    import tsel_pkg::*;
#(
    parameter int SOFT_W = 16,
    parameter int LVL_W  = $clog2(SOFT_W),
    parameter int TL_W   = 3
) (
    input  logic [NSRC-1:0]   pend,
    input  logic              hpriv,
    input  logic              ie,
    input  logic              tlz_en,
    input  logic [TL_W-1:0]   tl,
    input  logic [SOFT_W-1:0] softint,
    input  logic [LVL_W-1:0]  pil,
    output logic              hit,
    output src_e              src,
    output kind_e             kind,
    output logic [LVL_W-1:0]  lvl,
    output logic              clr_ok
);

    logic [LVL_W-1:0]  soft_lvl;
    logic [SOFT_W-1:0] lvl_mask;
    logic [SOFT_W-1:0] soft_rest;
    logic              soft_rest_any;
    logic              soft_gives_vec;
    logic              soft_eligible;
    logic              tlz_ok;

    tsel_softlvl #(.SW(SOFT_W), .LW(LVL_W)) u_lvl (
        .vec   (softint),
        .level (soft_lvl)
    );

    always_comb begin
        lvl_mask = '0;
        lvl_mask[soft_lvl] = 1'b1;
    end

    assign soft_rest      = softint & ~lvl_mask & {{(SOFT_W-1){1'b1}}, 1'b0};
    assign soft_rest_any  = |soft_rest;
    assign soft_gives_vec = pend[SRC_SOFT] && (soft_lvl < LVL_W'(VEC_SPLIT)) && pend[SRC_VEC];
    assign soft_eligible  = pend[SRC_SOFT] && !soft_gives_vec && (soft_lvl > pil);
    assign tlz_ok         = pend[SRC_TLZ] && tlz_en && (tl == '0);

    // Priority chain: order of the branches is the priority order.
    always_comb begin
        hit    = 1'b0;
        src    = SRC_TLZ;
        kind   = KIND_NONE;
        lvl    = '0;
        clr_ok = 1'b1;
        if (hpriv) begin
            if (ie) begin
                if (pend[SRC_TICK]) begin
                    hit = 1'b1; src = SRC_TICK; kind = KIND_TICK;
                end else if (pend[SRC_VEC]) begin
                    hit = 1'b1; src = SRC_VEC;  kind = KIND_VEC;
                end
            end
        end else begin
            if (tlz_ok) begin
                hit = 1'b1; src = SRC_TLZ;  kind = KIND_TLZ;
            end else if (pend[SRC_TICK]) begin
                hit = 1'b1; src = SRC_TICK; kind = KIND_TICK;
            end else if (ie) begin
                if (pend[SRC_CPU]) begin
                    hit = 1'b1; src = SRC_CPU;  kind = KIND_CPU;
                end else if (pend[SRC_DEV]) begin
                    hit = 1'b1; src = SRC_DEV;  kind = KIND_DEV;
                end else if (soft_gives_vec) begin
                    hit = 1'b1; src = SRC_VEC;  kind = KIND_VEC;
                end else if (soft_eligible) begin
                    hit    = 1'b1;
                    src    = SRC_SOFT;
                    kind   = KIND_SOFT;
                    lvl    = soft_lvl;
                    clr_ok = !soft_rest_any;
                end else if (pend[SRC_RERR]) begin
                    hit = 1'b1; src = SRC_RERR; kind = KIND_RERR;
                end
            end
        end
    end

endmodule

// File: rtl/tsel_pending.sv
module tsel_pending
    import tsel_pkg::*;
#(
    parameter int TYPE_W = 4,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              post_vld,
    input  logic [TYPE_W-1:0] post_type,
    input  logic              take,
    input  src_e              take_src,
    input  logic              take_clr,
    output logic [NSRC-1:0]   pend,
    output logic              any,
    output logic              err
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic              post_ok;
    logic [NSRC-1:0]   set_vec;
    logic [NSRC-1:0]   clr_vec;
    logic [NSRC-1:0]   pend_d;
    logic [NSRC-1:0]   pend_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              err_q;

    assign post_ok = post_vld && (post_type < TYPE_W'(NSRC));

    always_comb begin
        set_vec = '0;
        if (post_ok) begin
            set_vec[post_type[SRC_W-1:0]] = 1'b1;
        end
        clr_vec = '0;
        if (take && take_clr) begin
            clr_vec[take_src] = 1'b1;
        end
    end

    // Per-source flag update: a post at the same edge overrides a clear.
    for (genvar g = 0; g < NSRC; g++) begin : g_flag
        assign pend_d[g] = set_vec[g] | (pend_q[g] & ~clr_vec[g]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case ({post_ok, take})
                2'b10:   if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                2'b01:   if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= post_vld && !post_ok;
        end
    end

    assign pend = pend_q;
    assign any  = (cnt_q != '0);
    assign err  = err_q;

    p_err_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (post_vld && !post_ok && !take) |=> (pend_q == $past(pend_q)) && (cnt_q == $past(cnt_q)));

    p_sat_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && post_ok && !take) |=> (cnt_q == CNT_MAX));

    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && take && !post_ok) |=> (cnt_q == '0));

    p_take_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_clr && ((set_vec & clr_vec) == '0)) |=> ((pend_q & $past(clr_vec)) == '0));

    p_post_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (post_ok && take && take_clr && (post_type[SRC_W-1:0] == take_src))
        |=> (pend_q[$past(take_src)] && (cnt_q == $past(cnt_q))));

endmodule

// File: rtl/tsel_top.sv
module tsel_top
    import tsel_pkg::*;
#(
    parameter int TYPE_W = 4,
    parameter int CNT_W  = 4,
    parameter int TL_W   = 3,
    parameter int SOFT_W = 16,
    parameter int LVL_W  = $clog2(SOFT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              post_vld,
    input  logic [TYPE_W-1:0] post_type,
    input  logic              hpriv,
    input  logic              ie,
    input  logic              tlz_en,
    input  logic [TL_W-1:0]   tl,
    input  logic [SOFT_W-1:0] softint,
    input  logic [LVL_W-1:0]  pil,
    input  logic              req,
    output logic              irq_pending,
    output logic              post_err,
    output logic              resp_vld,
    output logic [2:0]        resp_kind,
    output logic [LVL_W-1:0]  resp_level
);

    rstate_e          state_q;
    rstate_e          state_d;
    logic [NSRC-1:0]  pend;
    logic             pk_hit;
    src_e             pk_src;
    kind_e            pk_kind;
    logic [LVL_W-1:0] pk_lvl;
    logic             pk_clr_ok;
    logic             take;
    kind_e            kind_q;
    logic [LVL_W-1:0] lvl_q;

    tsel_pick #(.SOFT_W(SOFT_W), .LVL_W(LVL_W), .TL_W(TL_W)) u_pick (
        .pend    (pend),
        .hpriv   (hpriv),
        .ie      (ie),
        .tlz_en  (tlz_en),
        .tl      (tl),
        .softint (softint),
        .pil     (pil),
        .hit     (pk_hit),
        .src     (pk_src),
        .kind    (pk_kind),
        .lvl     (pk_lvl),
        .clr_ok  (pk_clr_ok)
    );

    assign take = req && pk_hit;

    tsel_pending #(.TYPE_W(TYPE_W), .CNT_W(CNT_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .post_vld  (post_vld),
        .post_type (post_type),
        .take      (take),
        .take_src  (pk_src),
        .take_clr  (pk_clr_ok),
        .pend      (pend),
        .any       (irq_pending),
        .err       (post_err)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req) state_d = ST_RESP;
            ST_RESP: state_d = req ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Result capture at the request edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= KIND_NONE;
            lvl_q  <= '0;
        end else if (req) begin
            kind_q <= pk_kind;
            lvl_q  <= pk_lvl;
        end
    end

    // Outputs
    always_comb begin
        resp_vld   = 1'b0;
        resp_kind  = KIND_NONE;
        resp_level = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RESP: begin
                resp_vld   = 1'b1;
                resp_kind  = kind_q;
                resp_level = lvl_q;
            end
            default: ;
        endcase
    end

    p_resp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> resp_vld);

    p_resp_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !resp_vld);

    p_hv_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && hpriv && !ie) |=> (resp_kind == KIND_NONE));

    p_tlz_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && pk_src == SRC_TLZ) |-> (tlz_en && !hpriv && tl == '0));

    p_soft_above_pil_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && pk_src == SRC_SOFT) |-> (pk_lvl > pil));

    p_level_only_soft_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_vld && resp_kind != KIND_SOFT) |-> (resp_level == '0));

    p_vec_split_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && pk_src == SRC_SOFT) |-> !(pend[SRC_VEC] && pk_lvl < LVL_W'(VEC_SPLIT)));

endmodule

// File: tb/tsel_top_tb.sv
module tsel_top_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        post_vld;
    logic [3:0]  post_type;
    logic        hpriv;
    logic        ie;
    logic        tlz_en;
    logic [2:0]  tl;
    logic [15:0] softint;
    logic [3:0]  pil;
    logic        req;
    logic        irq_pending;
    logic        post_err;
    logic        resp_vld;
    logic [2:0]  resp_kind;
    logic [3:0]  resp_level;

    localparam logic [2:0] K_NONE = 3'd0, K_TLZ = 3'd1, K_TICK = 3'd2, K_VEC = 3'd3,
                           K_CPU  = 3'd4, K_DEV = 3'd5, K_SOFT = 3'd6, K_RERR = 3'd7;
    localparam logic [3:0] T_TLZ = 4'd0, T_TICK = 4'd1, T_VEC = 4'd2, T_CPU = 4'd3,
                           T_DEV = 4'd4, T_RERR = 4'd5, T_SOFT = 4'd6;

    typedef struct {
        logic [2:0] kind;
        logic [3:0] lvl;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t got;
    int   n_cmp  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    always #5 clk = ~clk;

    tsel_top u_dut (
        .clk(clk), .rst_n(rst_n), .post_vld(post_vld), .post_type(post_type),
        .hpriv(hpriv), .ie(ie), .tlz_en(tlz_en), .tl(tl), .softint(softint),
        .pil(pil), .req(req), .irq_pending(irq_pending), .post_err(post_err),
        .resp_vld(resp_vld), .resp_kind(resp_kind), .resp_level(resp_level)
    );

    // Monitor: pops one expected item per response pulse.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && resp_vld === 1'b1) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R4 unexpected response: kind=%0d level=%0d expected no pulse",
                         resp_kind, resp_level);
            end else begin
                got = exp_q.pop_front();
                if (resp_kind !== got.kind || resp_level !== got.lvl) begin
                    n_fail++;
                    $display("FAIL %s: kind=%0d level=%0d expected kind=%0d level=%0d",
                             got.tag, resp_kind, resp_level, got.kind, got.lvl);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic step(input bit pv, input logic [3:0] pt, input bit rq,
                        input logic [2:0] ek, input logic [3:0] el, input string tag);
        @(negedge clk);
        post_vld  = pv;
        post_type = pt;
        req       = rq;
        if (rq) exp_q.push_back('{ek, el, tag});
        @(negedge clk);
        post_vld = 1'b0;
        req      = 1'b0;
    endtask

    task automatic post(input logic [3:0] t);
        step(1'b1, t, 1'b0, K_NONE, 4'd0, "");
    endtask

    task automatic take(input logic [2:0] ek, input logic [3:0] el, input string tag);
        step(1'b0, 4'd0, 1'b1, ek, el, tag);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        summary();
    end

    initial begin
        rst_n = 1'b0; post_vld = 1'b0; post_type = '0; hpriv = 1'b0; ie = 1'b0;
        tlz_en = 1'b0; tl = '0; softint = '0; pil = '0; req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset irq_pending", irq_pending, 1'b0);
        chk("R4 reset resp_vld", resp_vld, 1'b0);
        chk("R2 reset post_err", post_err, 1'b0);

        take(K_NONE, 0, "R4 empty request");

        // R2: illegal types
        post(4'd9);
        chk("R2 err pulse type 9", post_err, 1'b1);
        chk("R2 no count on type 9", irq_pending, 1'b0);
        post(4'd7);
        chk("R2 err pulse type 7", post_err, 1'b1);
        @(negedge clk);
        chk("R2 err one cycle", post_err, 1'b0);
        take(K_NONE, 0, "R2 nothing pending after illegal");

        // R6: trap-level-zero gating
        post(T_TLZ);
        chk("R1 pending after post", irq_pending, 1'b1);
        take(K_NONE, 0, "R6 tlz disabled");
        tlz_en = 1'b1; tl = 3'd1;
        take(K_NONE, 0, "R6 tlz at tl 1");
        tl = 3'd0;
        take(K_TLZ, 0, "R6 tlz taken");
        chk("R10 count back to zero", irq_pending, 1'b0);

        // R6: trap-level-zero beats tick
        post(T_TICK); post(T_TLZ);
        take(K_TLZ, 0, "R6 tlz over tick");
        take(K_TICK, 0, "R7 tick after tlz");
        tlz_en = 1'b0;

        // R7: tick ignores enable, mondo needs it
        ie = 1'b0;
        post(T_TICK); post(T_CPU);
        take(K_TICK, 0, "R7 tick without ie");
        take(K_NONE, 0, "R7 cpu blocked without ie");
        ie = 1'b1;
        take(K_CPU, 0, "R7 cpu with ie");
        chk("R10 cleared after cpu", irq_pending, 1'b0);

        // R7: ordering cpu, dev, resumable
        post(T_RERR); post(T_DEV); post(T_CPU);
        take(K_CPU, 0, "R7 order cpu");
        take(K_DEV, 0, "R7 order dev");
        take(K_RERR, 0, "R7 order resumable");

        // R5: hypervisor mode
        hpriv = 1'b1; ie = 1'b0;
        post(T_TICK); post(T_VEC); post(T_CPU);
        take(K_NONE, 0, "R5 hv without ie");
        ie = 1'b1;
        take(K_TICK, 0, "R5 hv tick first");
        take(K_VEC, 0, "R5 hv vector second");
        take(K_NONE, 0, "R5 hv ignores cpu");
        hpriv = 1'b0;
        take(K_CPU, 0, "R7 cpu after leaving hv");
        chk("R10 all taken", irq_pending, 1'b0);

        // R8: soft levels
        softint = 16'h0001;
        post(T_SOFT);
        take(K_NONE, 0, "R8 bit0 only gives level 0");
        softint = 16'h0100; pil = 4'd8;
        take(K_NONE, 0, "R8 level equal to pil");
        pil = 4'd7;
        take(K_SOFT, 4'd8, "R8 level 8 above pil 7");
        take(K_NONE, 0, "R10 soft flag cleared");
        chk("R10 soft count zero", irq_pending, 1'b0);
        pil = 4'd0;

        // R10/R3: soft flag survives while bits remain, counter floors at zero
        softint = 16'h0300;
        post(T_SOFT);
        take(K_SOFT, 4'd9, "R10 soft level 9");
        chk("R3 count zero after soft take", irq_pending, 1'b0);
        take(K_SOFT, 4'd9, "R10 soft still pending");
        softint = 16'h0100;
        take(K_SOFT, 4'd8, "R10 soft last level");
        chk("R3 no underflow", irq_pending, 1'b0);
        take(K_NONE, 0, "R10 soft finally cleared");

        // R9: vector between levels 5 and 6
        softint = 16'h0010;
        post(T_VEC); post(T_SOFT);
        take(K_VEC, 0, "R9 vector preempts level 4");
        take(K_SOFT, 4'd4, "R9 level 4 after vector");
        softint = 16'h0040;
        post(T_VEC); post(T_SOFT);
        take(K_SOFT, 4'd6, "R9 level 6 beats vector");
        take(K_NONE, 0, "R9 vector waits without soft");
        hpriv = 1'b1;
        take(K_VEC, 0, "R5 vector taken in hv");
        hpriv = 1'b0; softint = '0;
        chk("R10 idle after vector test", irq_pending, 1'b0);

        // R11: post and take of the same source at one edge
        post(T_CPU);
        step(1'b1, T_CPU, 1'b1, K_CPU, 0, "R11 take during post");
        chk("R11 still counted", irq_pending, 1'b1);
        take(K_CPU, 0, "R11 source still pending");
        chk("R11 drained", irq_pending, 1'b0);

        // R1: counter, not flags, drives irq_pending
        post(T_TICK); post(T_TICK);
        take(K_TICK, 0, "R1 tick once");
        take(K_NONE, 0, "R1 no flag left");
        chk("R1 pending from count", irq_pending, 1'b1);

        // R3: saturation (1 + 15 posts would wrap a 4-bit counter to 0)
        for (int i = 0; i < 15; i++) post(T_DEV);
        chk("R3 saturated not wrapped", irq_pending, 1'b1);
        take(K_DEV, 0, "R3 dev after saturation");
        chk("R3 still pending after take", irq_pending, 1'b1);

        repeat (3) @(negedge clk);
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R4 missing responses: got %0d outstanding expected 0", exp_q.size());
        end
        summary();
    end

endmodule